// File: doc/BRIEF.md
# Device Command Mailbox

This block is the register face of a device command mailbox. A host reaches it over a simple byte-addressed register bus. The host loads a command word and an input payload, then rings a doorbell. The block then holds off further host writes and hands the command to a separate command handler over a valid/ready request. It gives that handler a frozen snapshot of the input bytes and a write port into the now-cleared payload window. When the handler signals done, the block writes the handler's results into its registers and drops the doorbell, which tells the host the command has finished.

The block also shows the host the progress of a long-running background operation. It builds a background-status word from progress inputs. An 8-byte read of the status register clears the background-running flag once progress is nonzero. Register offsets: capability 0x00, control 0x04, command 0x08, status 0x10, background status 0x18, payload window from 0x20.

Top module: `mbox_regs`

## Requirements
- R1: After reset, bus_rvalid and hnd_req_valid are 0, and the control, command and status registers and every payload byte read as zero.
- R2: A read (bus_size 0,1,2,3 = 1,2,4,8 bytes, address aligned to the size) returns in the next cycle, with bus_rvalid high, the little-endian bytes at that address, zero-extended.
- R3: A write at or above offset 0x20 of any size stores its bytes at payload byte (address - 0x20) onward.
- R4: The control register at 0x04 changes only on a 4-byte write, and its bit 0 is the doorbell. A write of any other size there is ignored. The capability register at 0x00 ignores writes.
- R5: The command register at 0x08 is written only by an 8-byte write, and bits above 36 are dropped. Its fields are command [7:0], command set [15:8] and length [36:16]. The status register at 0x10 ignores writes.
- R6: Two clock edges after the doorbell write is sampled, hnd_req_valid rises with hnd_set, hnd_cmd and hnd_len_in taken from the command register. It stays high, with those values held, until hnd_req_ready is seen.
- R7: On the edge that issues the request, the whole payload window is cleared to zero, and its prior contents are frozen into a snapshot that hnd_rd_data returns combinationally for hnd_rd_addr.
- R8: While the doorbell is set, every host write is ignored, including writes to the command register, the payload and the control register.
- R9: A hnd_done seen after the handshake rebuilds status with bit 0 = hnd_bg_started and [47:32] = hnd_rc, all other bits zero. It replaces the command length field with hnd_len_out and clears the doorbell, all on that one edge.
- R10: A read at 0x18 returns bg_opcode in [15:0], bg_pct in [22:16] and bg_rc in [47:32], with zeros elsewhere.
- R11: An 8-byte status read while bg_pct is nonzero returns, and stores, status bit 0 cleared. Narrower reads, or reads while bg_pct is zero, leave it unchanged.
- R12: The capability register reads 0x92B: payload size exponent 11 in [4:0], background interrupt capability 1 in bit 5, interrupt message number 9 in [11:8].
- R13: While a command is in progress, a hnd_wr_en strobe stores hnd_wr_data at payload byte hnd_wr_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address within the mailbox |
| bus_size | input | 2 | Access size code: 1, 2, 4 or 8 bytes |
| bus_wdata | input | 64 | Write data, least significant byte at the address |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| bus_rdata | output | 64 | Read data |
| hnd_req_valid | output | 1 | Command request to handler |
| hnd_req_ready | input | 1 | Handler accepts request |
| hnd_set | output | 8 | Command set |
| hnd_cmd | output | 8 | Command |
| hnd_len_in | output | 21 | Input payload length |
| hnd_rd_addr | input | 11 | Snapshot byte address |
| hnd_rd_data | output | 8 | Snapshot byte |
| hnd_wr_en | input | 1 | Handler payload write strobe |
| hnd_wr_addr | input | 11 | Handler payload byte address |
| hnd_wr_data | input | 8 | Handler payload byte |
| hnd_done | input | 1 | Handler completion pulse |
| hnd_rc | input | 16 | Return code |
| hnd_len_out | input | 21 | Output payload length |
| hnd_bg_started | input | 1 | Handler started a background operation |
| bg_opcode | input | 16 | Current background opcode |
| bg_pct | input | 7 | Background completion percentage |
| bg_rc | input | 16 | Background return code |

## Verification
Read data is due one cycle after the read strobe. The request is due two edges after the doorbell write. Clearing, snapshot, completion results and the doorbell drop each land on a single edge. A behavioural model in the bench advances on every rising edge from the same inputs. All outputs are compared with that model a little after each falling edge, so every comparison sees settled values at a known cycle. Directed reads at hand-computed points then confirm each result with a literal expected value.

// File: rtl/mbox_regs.sv
module mbox_regs #(
  parameter int PAY_BYTES = 2048,
  parameter int LEN_W     = 21,
  parameter int MSG_NUM   = 9,
  parameter int AW        = $clog2(32 + PAY_BYTES),
  parameter int PW        = $clog2(PAY_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [1:0]       bus_size,
  input  logic [63:0]      bus_wdata,
  output logic             bus_rvalid,
  output logic [63:0]      bus_rdata,
  output logic             hnd_req_valid,
  input  logic             hnd_req_ready,
  output logic [7:0]       hnd_set,
  output logic [7:0]       hnd_cmd,
  output logic [LEN_W-1:0] hnd_len_in,
  input  logic [PW-1:0]    hnd_rd_addr,
  output logic [7:0]       hnd_rd_data,
  input  logic             hnd_wr_en,
  input  logic [PW-1:0]    hnd_wr_addr,
  input  logic [7:0]       hnd_wr_data,
  input  logic             hnd_done,
  input  logic [15:0]      hnd_rc,
  input  logic [LEN_W-1:0] hnd_len_out,
  input  logic             hnd_bg_started,
  input  logic [15:0]      bg_opcode,
  input  logic [6:0]       bg_pct,
  input  logic [15:0]      bg_rc
);
  localparam int          PAY_BASE = 32;
  localparam logic [31:0] CAP      = 32'($clog2(PAY_BYTES)) | (32'd1 << 5) | (32'(MSG_NUM) << 8);
  localparam logic [63:0] CMD_MASK = (64'd1 << (16 + LEN_W)) - 64'd1;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;

  logic [7:0]  pay  [PAY_BYTES];
  logic [7:0]  snap [PAY_BYTES];
  logic        db;
  logic [63:0] cmd_q, sts_q;
  st_t         st;

  wire          is_pay  = bus_addr >= AW'(PAY_BASE);
  wire [AW-1:0] pofs    = bus_addr - AW'(PAY_BASE);
  wire [AW-1:0] pbase   = {pofs[AW-1:3], 3'b000};
  wire [3:0]    nbytes  = 4'd1 << bus_size;
  wire          trig    = db && (st == S_IDLE);
  wire          sts_rd8 = bus_rd && (bus_size == 2'd3) && (bus_addr == AW'(16));
  wire [63:0]   sts_view = (sts_rd8 && bg_pct != '0) ? (sts_q & ~64'd1) : sts_q;
  wire [63:0]   bg_word  = {16'd0, bg_rc, 9'd0, bg_pct, bg_opcode};

  assign hnd_req_valid = (st == S_REQ);
  assign hnd_cmd       = cmd_q[7:0];
  assign hnd_set       = cmd_q[15:8];
  assign hnd_len_in    = cmd_q[16 +: LEN_W];
  assign hnd_rd_data   = snap[hnd_rd_addr];

  logic [63:0] slot, rd_val;
  always_comb begin
    slot = '0;
    if (is_pay) begin
      for (int k = 0; k < 8; k++)
        if (int'(pbase) + k < PAY_BYTES) slot[8*k +: 8] = pay[PW'(int'(pbase) + k)];
    end else begin
      case (bus_addr[4:3])
        2'd0:    slot = {31'd0, db, CAP};
        2'd1:    slot = cmd_q;
        2'd2:    slot = sts_view;
        default: slot = bg_word;
      endcase
    end
    rd_val = slot >> {bus_addr[2:0], 3'b000};
    case (bus_size)
      2'd0:    rd_val = rd_val & 64'hFF;
      2'd1:    rd_val = rd_val & 64'hFFFF;
      2'd2:    rd_val = rd_val & 64'hFFFF_FFFF;
      default: rd_val = rd_val;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db         <= 1'b0;
      cmd_q      <= '0;
      sts_q      <= '0;
      st         <= S_IDLE;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_val;
      if (sts_rd8) sts_q <= sts_view;
      if (bus_wr && !db && !is_pay) begin
        if (bus_size == 2'd2 && bus_addr == AW'(4)) db <= bus_wdata[0];
        if (bus_size == 2'd3 && bus_addr == AW'(8)) cmd_q <= bus_wdata & CMD_MASK;
      end
      case (st)
        S_IDLE: if (db) st <= S_REQ;
        S_REQ:  if (hnd_req_ready) st <= S_WAIT;
        default:
          if (hnd_done) begin
            st    <= S_IDLE;
            db    <= 1'b0;
            sts_q <= {16'd0, hnd_rc, 31'd0, hnd_bg_started};
            cmd_q[16 +: LEN_W] <= hnd_len_out;
          end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAY_BYTES; i++) pay[i] <= '0;
    end else if (trig) begin
      for (int i = 0; i < PAY_BYTES; i++) pay[i] <= '0;
    end else begin
      if (bus_wr && !db && is_pay)
        for (int k = 0; k < 8; k++)
          if (k < int'(nbytes) && int'(pofs) + k < PAY_BYTES)
            pay[PW'(int'(pofs) + k)] <= bus_wdata[8*k +: 8];
      if (hnd_wr_en && st != S_IDLE) pay[hnd_wr_addr] <= hnd_wr_data;
    end
  end

  always_ff @(posedge clk)
    if (trig)
      for (int i = 0; i < PAY_BYTES; i++) snap[i] <= pay[i];
endmodule

// File: rtl/mbox_regs_chk.sv
module mbox_regs_chk #(
  parameter int AW    = 12,
  parameter int LEN_W = 21
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_rd,
  input logic [AW-1:0]    bus_addr,
  input logic [1:0]       bus_size,
  input logic             bus_rvalid,
  input logic [63:0]      bus_rdata,
  input logic [6:0]       bg_pct,
  input logic             hnd_req_valid,
  input logic             hnd_req_ready,
  input logic [7:0]       hnd_set,
  input logic [7:0]       hnd_cmd,
  input logic [LEN_W-1:0] hnd_len_in,
  input logic             hnd_done,
  input logic             db
);
  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  a_r6_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    hnd_req_valid && !hnd_req_ready |=> hnd_req_valid && $stable(hnd_set) && $stable(hnd_cmd) && $stable(hnd_len_in));

  a_r6_request_needs_doorbell: assert property (@(posedge clk) disable iff (!rst_n)
    hnd_req_valid |-> db);

  a_r8_busy_command_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    db |=> $stable(hnd_set) && $stable(hnd_cmd));

  a_r9_doorbell_drop_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(db) |-> $past(hnd_done));

  a_r11_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_size == 2'd3 && bus_addr == AW'(16) && bg_pct != '0 |=> bus_rdata[0] == 1'b0);

  a_r12_capability_value: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_size == 2'd2 && bus_addr == AW'(0) |=> bus_rdata[31:0] == 32'h0000_092B);
endmodule

bind mbox_regs mbox_regs_chk #(.AW(AW), .LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_size(bus_size),
  .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .bg_pct(bg_pct),
  .hnd_req_valid(hnd_req_valid), .hnd_req_ready(hnd_req_ready), .hnd_set(hnd_set),
  .hnd_cmd(hnd_cmd), .hnd_len_in(hnd_len_in), .hnd_done(hnd_done), .db(db)
);

// File: tb/mbox_regs_tb_top.sv
module mbox_regs_tb_top;
  localparam int PAY = 2048;
  localparam int AW  = 12;
  localparam int PW  = 11;
  localparam int LW  = 21;

  logic clk = 0;
  logic rst_n = 0;
  always #10 clk = ~clk;

  logic bus_wr = 0, bus_rd = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [1:0] bus_size = '0;
  logic [63:0] bus_wdata = '0;
  logic bus_rvalid;
  logic [63:0] bus_rdata;
  logic hnd_req_valid, hnd_req_ready = 0;
  logic [7:0] hnd_set, hnd_cmd, hnd_rd_data;
  logic [LW-1:0] hnd_len_in, hnd_len_out = '0;
  logic [PW-1:0] hnd_rd_addr = '0, hnd_wr_addr = '0;
  logic hnd_wr_en = 0, hnd_done = 0, hnd_bg_started = 0;
  logic [7:0] hnd_wr_data = '0;
  logic [15:0] hnd_rc = '0, bg_opcode = '0, bg_rc = '0;
  logic [6:0] bg_pct = '0;

  mbox_regs dut_i (.*);

  int checks = 0, fails = 0;
  bit done_flag = 0;

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0] pay_m [PAY];
  logic [7:0] snap_m [PAY];
  logic [63:0] cmd_m, sts_m, rd_m;
  bit db_m, rv_m, snap_ok;
  int st_m, so;
  bit dbo;
  localparam logic [31:0] CAP_M = 32'd11 | (32'd1 << 5) | (32'd9 << 8);

  function automatic logic [7:0] mbyte(int a);
    logic [63:0] bgw;
    bgw = {16'd0, bg_rc, 9'd0, bg_pct, bg_opcode};
    if (a < 4)  return CAP_M[8*a +: 8];
    if (a < 8)  return (a == 4) ? {7'd0, db_m} : 8'd0;
    if (a < 16) return cmd_m[8*(a-8) +: 8];
    if (a < 24) return sts_m[8*(a-16) +: 8];
    if (a < 32) return bgw[8*(a-24) +: 8];
    if (a - 32 < PAY) return pay_m[a-32];
    return 8'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (pay_m[i]) pay_m[i] = 8'd0;
      cmd_m = 0; sts_m = 0; rd_m = 0; db_m = 0; rv_m = 0; st_m = 0; snap_ok = 0;
    end else begin
      so = st_m; dbo = db_m;
      rv_m = bus_rd;
      if (bus_rd) begin
        if (bus_size == 3 && bus_addr == 16 && bg_pct != 0) sts_m[0] = 1'b0;
        rd_m = 0;
        for (int k = 0; k < (1 << bus_size); k++) rd_m[8*k +: 8] = mbyte(int'(bus_addr) + k);
      end
      if (so == 0 && dbo) begin
        snap_m = pay_m; snap_ok = 1;
        foreach (pay_m[i]) pay_m[i] = 8'd0;
        st_m = 1;
      end else if (so == 1 && hnd_req_ready) st_m = 2;
      else if (so == 2 && hnd_done) begin
        sts_m = 0; sts_m[0] = hnd_bg_started; sts_m[47:32] = hnd_rc;
        cmd_m[36:16] = hnd_len_out; db_m = 0; st_m = 0;
      end
      if (so != 0 && hnd_wr_en) pay_m[hnd_wr_addr] = hnd_wr_data;
      if (bus_wr && !dbo) begin
        if (bus_addr >= 32) begin
          for (int k = 0; k < (1 << bus_size); k++)
            if (int'(bus_addr) - 32 + k < PAY) pay_m[int'(bus_addr) - 32 + k] = bus_wdata[8*k +: 8];
        end else if (bus_size == 2 && bus_addr == 4) db_m = bus_wdata[0];
        else if (bus_size == 3 && bus_addr == 8) cmd_m = bus_wdata & ((64'd1 << 37) - 1);
      end
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n && !done_flag) begin
      chk("R2 rvalid", {63'd0, bus_rvalid}, {63'd0, rv_m});
      if (rv_m) chk("R2 rdata", bus_rdata, rd_m);
      chk("R6 req_valid", {63'd0, hnd_req_valid}, {63'd0, st_m == 1});
      if (st_m == 1) chk("R6 fields", {27'd0, hnd_len_in, hnd_set, hnd_cmd}, {27'd0, cmd_m[36:0]});
      if (snap_ok) chk("R7 snapshot port", {56'd0, hnd_rd_data}, {56'd0, snap_m[hnd_rd_addr]});
    end
  end

  task automatic bwrite(int a, int sz, logic [63:0] d);
    bus_wr = 1; bus_addr = AW'(a); bus_size = 2'(sz); bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic bread(int a, int sz, output logic [63:0] v);
    bus_rd = 1; bus_addr = AW'(a); bus_size = 2'(sz);
    @(negedge clk);
    bus_rd = 0;
    v = bus_rdata;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 rvalid", {63'd0, bus_rvalid}, 64'd0);
    chk("R1 req", {63'd0, hnd_req_valid}, 64'd0);
    bread(4, 2, v);  chk("R1 control", v, 64'd0);
    bread(8, 3, v);  chk("R1 command", v, 64'd0);
    bread(16, 3, v); chk("R1 status", v, 64'd0);
    bread(32, 3, v); chk("R1 payload", v, 64'd0);
    bread(0, 2, v);  chk("R12 capability", v, 64'h92B);

    bwrite(32, 3, 64'h8877_6655_4433_2211);
    bwrite(40, 1, 64'hBBAA);
    bwrite(43, 0, 64'hCC);
    bread(40, 3, v); chk("R3 mixed sizes", v, 64'h0000_0000_CC00_BBAA);
    bread(36, 2, v); chk("R2 4-byte read", v, 64'h8877_6655);
    bread(33, 0, v); chk("R2 1-byte read", v, 64'h22);
    bread(38, 1, v); chk("R2 2-byte read", v, 64'h8877);

    bwrite(8, 3, 64'hFFFF_0000_000A_1234);
    bread(8, 3, v);  chk("R5 command masked", v, 64'h000A_1234);
    bread(12, 2, v); chk("R5 command upper", v, 64'd0);
    bwrite(8, 2, 64'h5555);
    bread(8, 3, v);  chk("R5 narrow command write ignored", v, 64'h000A_1234);
    bwrite(16, 3, '1);
    bread(16, 3, v); chk("R5 status ignores writes", v, 64'd0);
    bwrite(0, 3, 64'h0000_0001_0000_0000);
    bread(4, 2, v);  chk("R4 8-byte doorbell ignored", v, 64'd0);
    chk("R4 no request", {63'd0, hnd_req_valid}, 64'd0);
    bwrite(0, 2, 64'hFFFF_FFFF);
    bread(0, 2, v);  chk("R4 capability ignores writes", v, 64'h92B);

    bwrite(4, 2, 64'd1);
    @(negedge clk);
    chk("R6 request raised", {63'd0, hnd_req_valid}, 64'd1);
    chk("R6 set/cmd/len", {27'd0, hnd_len_in, hnd_set, hnd_cmd}, 64'h000A_1234);
    hnd_rd_addr = 0; #1;
    chk("R7 snapshot byte 0", {56'd0, hnd_rd_data}, 64'h11);
    hnd_rd_addr = 9; #1;
    chk("R7 snapshot byte 9", {56'd0, hnd_rd_data}, 64'hBB);
    @(negedge clk);
    bread(32, 3, v); chk("R7 payload cleared", v, 64'd0);
    bread(40, 3, v); chk("R7 payload cleared high", v, 64'd0);
    bwrite(32, 3, '1);
    bwrite(8, 3, 64'h5678);
    bwrite(4, 2, 64'd0);
    bread(4, 2, v);  chk("R8 doorbell kept", v, 64'd1);
    bread(32, 3, v); chk("R8 payload write ignored", v, 64'd0);
    bread(8, 3, v);  chk("R8 command write ignored", v, 64'h000A_1234);
    chk("R6 request still held", {63'd0, hnd_req_valid}, 64'd1);
    hnd_req_ready = 1; @(negedge clk); hnd_req_ready = 0;
    chk("R6 request dropped", {63'd0, hnd_req_valid}, 64'd0);
    hnd_wr_en = 1;
    hnd_wr_addr = 0; hnd_wr_data = 8'hDE; @(negedge clk);
    hnd_wr_addr = 1; hnd_wr_data = 8'hAD; @(negedge clk);
    hnd_wr_addr = 2; hnd_wr_data = 8'hBE; @(negedge clk);
    hnd_wr_en = 0;
    hnd_done = 1; hnd_rc = 16'h0005; hnd_len_out = 21'd3; hnd_bg_started = 1;
    @(negedge clk);
    hnd_done = 0;
    bread(4, 2, v);  chk("R9 doorbell cleared", v, 64'd0);
    bread(8, 3, v);  chk("R9 length replaced", v, 64'h0003_1234);
    bread(16, 3, v); chk("R9 status rebuilt", v, 64'h0000_0005_0000_0001);
    bread(32, 3, v); chk("R13 handler output", v, 64'h0000_0000_00BE_ADDE);
    bread(40, 3, v); chk("R13 rest zero", v, 64'd0);
    chk("R8 no second request", {63'd0, hnd_req_valid}, 64'd0);

    bg_opcode = 16'h4401; bg_pct = 7'd50; bg_rc = 16'h0007;
    bread(24, 3, v); chk("R10 background word", v, 64'h0000_0007_0032_4401);
    bread(28, 2, v); chk("R10 background rc", v, 64'h7);
    bread(16, 2, v); chk("R11 narrow read keeps flag", v, 64'h1);
    bread(16, 3, v); chk("R11 8-byte read clears flag", v, 64'h0000_0005_0000_0000);
    bread(16, 2, v); chk("R11 flag stored cleared", v, 64'h0);

    bwrite(4, 2, 64'd1);
    @(negedge clk);
    hnd_req_ready = 1; @(negedge clk); hnd_req_ready = 0;
    bg_pct = 7'd0;
    hnd_done = 1; hnd_rc = 16'h0000; hnd_len_out = 21'd0; hnd_bg_started = 1;
    @(negedge clk);
    hnd_done = 0;
    bread(16, 3, v); chk("R11 zero progress keeps flag", v, 64'h1);
    bread(8, 3, v);  chk("R9 zero output length", v, 64'h0000_1234);

    repeat (2) @(negedge clk);
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule